// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Compare Output and PWM

This block counts timer ticks in an 8-bit register and compares that count with a compare value on every tick. A clock-select stage makes the ticks. They can come from a free-running 10-bit prescaler on the system clock, or from edges on an external pin after the pin is synchronized. A third choice gives no ticks at all, which freezes the counter. Four counting modes use the counter and the compare value:

- plain wrap-around counting;
- clear-on-compare, where the compare value sets the period;
- clear-on-compare with a toggling output, for frequency generation;
- dual-slope phase-correct PWM, where the compare value is double-buffered.

Software reaches the block through a write port with four addresses: control, counter, compare and flags. Two sticky flags record overflow and compare-match events. Each flag has its own mask, and the masked flags are ORed onto one interrupt line. The control, counter and compare registers are not read back. The counter value, the waveform output and both flags are visible as output ports.

Top module: `tc8_timer`

## Requirements
- R1: While reset is applied, and for the two clocks after it is released, the outputs read: count 0, waveform output 0, both flags 0, irq 0. Clock select reads off, the mode reads wrap-around, and both masks read 0.
- R2: The control register is address 0. Bits [2:0] select the tick source: 0 off, 1 every clock, 2 every 8th clock, 3 every 64th, 4 every 256th, 5 every 1024th, 6 external falling edge, 7 external rising edge. The divided sources tick when the low 3, 6, 8 or 10 bits of the prescaler are all ones. With the source off, the count holds.
- R3: The external pin passes through two synchronizing flops. An edge of the selected polarity produces one tick. The count changes on the third rising clock edge after the pin changes.
- R4: Control bits [4:3] select the mode: 0 wrap-around, 1 phase-correct PWM, 2 clear-on-compare, 3 clear-on-compare with toggle. In mode 0 the count goes up by 1 per tick, wraps from 0xFF to 0x00, and sets the overflow flag on that wrap.
- R5: In modes 2 and 3, a tick while the count equals the compare value loads 0. The overflow flag is set only by a tick at 0xFF.
- R6: In mode 3 every compare match inverts the waveform output. In modes 0 and 2 a match leaves the output unchanged.
- R7: In mode 1 the count rises to 0xFF and then falls to 0x00, reversing direction at each end. The overflow flag is set by the tick taken at 0x00 while counting down.
- R8: The compare register is address 2. In mode 1 a written value takes effect only on the tick taken at 0xFF while counting up. In the other modes it takes effect on the next clock.
- R9: In mode 1 a compare match drives the output to 0 while counting up and to 1 while counting down.
- R10: The counter register is address 1. A write to it takes priority over a tick in the same cycle, and that tick is dropped. The next tick after the write produces no compare match: no flag is set and the output does not change. A clear-on-compare reload still happens on that tick.
- R11: Address 3 holds the flags. Writing 1 to bit 0 clears the overflow flag and writing 1 to bit 1 clears the compare flag. A hardware set in the same cycle wins over the clear. The same write loads the overflow mask from bit 4 and the compare mask from bit 5. irq is the OR of each flag ANDed with its mask.
- R12: Writing control bit 6 as 1 clears the prescaler. Its count restarts from zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 counter, 2 compare, 3 flags/masks |
| wr_data | input | 8 | Write data |
| ext_pin | input | 1 | External count input |
| cnt | output | 8 | Current count |
| wave_out | output | 1 | Compare waveform output |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that ext_pin is free of glitches on the scale of a few clocks. They also assume that counter writes stand apart from the events the assertions reason about, and several properties simply exclude any cycle that carries a counter write. The stimulus holds each pin level for at least three clocks and issues only isolated one-cycle writes. Mode and compare changes are spaced far enough apart for full PWM periods to complete, including the compare extremes 0x00 and 0xFF.

// File: rtl/tc8_pkg.sv
`timescale 1ns/1ps
package tc8_pkg;
  typedef enum logic [1:0] {
    MD_FREE   = 2'd0,
    MD_PWM    = 2'd1,
    MD_CLR    = 2'd2,
    MD_TOGGLE = 2'd3
  } tc_mode_e;

  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } tc_csel_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  localparam int NTAP = 4;

  // number of low prescaler bits that must all be one for each divided tap
  function automatic int psc_tap_bits(int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tc8_clksel.sv
`timescale 1ns/1ps
module tc8_clksel
  import tc8_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tc_csel_e csel,
  input  logic     psc_clr,
  input  logic     ext_pin,
  output logic     tick
);
  localparam int SYNC_N = 3;

  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic [NTAP-1:0]   tap_hit;
  logic              pin_rise, pin_fall;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int TW = psc_tap_bits(i);
    assign tap_hit[i] = &psc_q[TW-1:0];
  end

  always_comb begin
    psc_d    = psc_clr ? '0 : psc_q + 1'b1;
    sync_d   = {sync_q[SYNC_N-2:0], ext_pin};
    pin_rise = sync_q[1] & ~sync_q[2];
    pin_fall = ~sync_q[1] & sync_q[2];
    unique case (csel)
      CS_OFF:      tick = 1'b0;
      CS_DIV1:     tick = 1'b1;
      CS_DIV8:     tick = tap_hit[0];
      CS_DIV64:    tick = tap_hit[1];
      CS_DIV256:   tick = tap_hit[2];
      CS_DIV1024:  tick = tap_hit[3];
      CS_EXT_FALL: tick = pin_fall;
      CS_EXT_RISE: tick = pin_rise;
      default:     tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      sync_q <= '0;
    end else begin
      psc_q  <= psc_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/tc8_core.sv
`timescale 1ns/1ps
module tc8_core
  import tc8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tc_mode_e         mode,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_act_q,
  output logic             wave_q,
  output logic             ovf_ev,
  output logic             match_ev
);
  localparam logic [CNT_W-1:0] TOP_V = '1;
  localparam logic [CNT_W-1:0] BOT_V = '0;

  logic [CNT_W-1:0] cnt_d, cmp_act_d, cmp_buf_q, cmp_buf_d;
  logic             up_q, up_d, blk_q, blk_d, wave_d;
  logic             tick_eff, hit, is_pwm, at_top, at_bot;

  always_comb begin
    tick_eff = tick & ~cnt_wr;
    hit      = (cnt_q == cmp_act_q);
    is_pwm   = (mode == MD_PWM);
    at_top   = (cnt_q == TOP_V);
    at_bot   = (cnt_q == BOT_V);
    match_ev = tick_eff & ~blk_q & hit;
    ovf_ev   = tick_eff & (is_pwm ? (~up_q & at_bot) : at_top);

    cnt_d = cnt_q;
    if (cnt_wr) begin
      cnt_d = wr_data;
    end else if (tick_eff) begin
      unique case (mode)
        MD_FREE:           cnt_d = cnt_q + 1'b1;
        MD_CLR, MD_TOGGLE: cnt_d = hit ? BOT_V : cnt_q + 1'b1;
        MD_PWM: begin
          if (up_q) cnt_d = at_top ? cnt_q - 1'b1 : cnt_q + 1'b1;
          else      cnt_d = at_bot ? cnt_q + 1'b1 : cnt_q - 1'b1;
        end
        default:           cnt_d = cnt_q;
      endcase
    end

    if (!is_pwm)       up_d = 1'b1;
    else if (tick_eff) up_d = up_q ? ~at_top : at_bot;
    else               up_d = up_q;

    blk_d = cnt_wr ? 1'b1 : (tick_eff ? 1'b0 : blk_q);

    cmp_buf_d = cmp_wr ? wr_data : cmp_buf_q;
    if (!is_pwm)                         cmp_act_d = cmp_buf_d;
    else if (tick_eff & up_q & at_top)   cmp_act_d = cmp_buf_q;
    else                                 cmp_act_d = cmp_act_q;

    wave_d = wave_q;
    if (match_ev) begin
      if (is_pwm)                 wave_d = ~up_q;
      else if (mode == MD_TOGGLE) wave_d = ~wave_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
      up_q      <= 1'b1;
      blk_q     <= 1'b0;
      wave_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      cmp_buf_q <= cmp_buf_d;
      cmp_act_q <= cmp_act_d;
      up_q      <= up_d;
      blk_q     <= blk_d;
      wave_q    <= wave_d;
    end
  end
endmodule

// File: rtl/tc8_flags.sv
`timescale 1ns/1ps
module tc8_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_ev,
  input  logic             reg_wr,
  input  logic [NFLAG-1:0] clr_bits,
  input  logic [NFLAG-1:0] mask_bits,
  output logic [NFLAG-1:0] flag_q,
  output logic             irq
);
  logic [NFLAG-1:0] flag_d, mask_q, mask_d;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_d[i] = set_ev[i] | (flag_q[i] & ~(reg_wr & clr_bits[i]));
  end

  always_comb begin
    mask_d = reg_wr ? mask_bits : mask_q;
    irq    = |(flag_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/tc8_timer.sv
`timescale 1ns/1ps
module tc8_timer #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_pin,
  output logic [CNT_W-1:0] cnt,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic             irq
);
  import tc8_pkg::*;

  logic [1:0]       rsync_q;
  logic             rst_i;
  tc_csel_e         csel_q, csel_d;
  tc_mode_e         mode_q, mode_d;
  logic             wr_ctrl, wr_cnt, wr_cmp, wr_flag, psc_clr, tick;
  logic             ovf_ev, match_ev;
  logic [CNT_W-1:0] cmp_act;
  logic [1:0]       flags;

  // reset asserts at once and releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == A_CTRL);
    wr_cnt  = wr_en && (wr_addr == A_CNT);
    wr_cmp  = wr_en && (wr_addr == A_CMP);
    wr_flag = wr_en && (wr_addr == A_FLAG);
    psc_clr = wr_ctrl & wr_data[6];
    csel_d  = csel_q;
    mode_d  = mode_q;
    if (wr_ctrl) begin
      csel_d = tc_csel_e'(wr_data[2:0]);
      mode_d = tc_mode_e'(wr_data[4:3]);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      csel_q <= CS_OFF;
      mode_q <= MD_FREE;
    end else begin
      csel_q <= csel_d;
      mode_q <= mode_d;
    end
  end

  tc8_clksel #(.PSC_W(PSC_W)) u_clksel (
    .clk     (clk),
    .rst_n   (rst_i),
    .csel    (csel_q),
    .psc_clr (psc_clr),
    .ext_pin (ext_pin),
    .tick    (tick)
  );

  tc8_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_i),
    .tick      (tick),
    .mode      (mode_q),
    .cnt_wr    (wr_cnt),
    .cmp_wr    (wr_cmp),
    .wr_data   (wr_data),
    .cnt_q     (cnt),
    .cmp_act_q (cmp_act),
    .wave_q    (wave_out),
    .ovf_ev    (ovf_ev),
    .match_ev  (match_ev)
  );

  tc8_flags #(.NFLAG(2)) u_flags (
    .clk       (clk),
    .rst_n     (rst_i),
    .set_ev    ({match_ev, ovf_ev}),
    .reg_wr    (wr_flag),
    .clr_bits  (wr_data[1:0]),
    .mask_bits (wr_data[5:4]),
    .flag_q    (flags),
    .irq       (irq)
  );

  assign ovf_flag = flags[0];
  assign cmp_flag = flags[1];
endmodule

// File: rtl/tc8_timer_chk.sv
`timescale 1ns/1ps
module tc8_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_i,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             wr_d0,
  input logic [2:0]       csel,
  input logic [1:0]       mode,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic             wave_out,
  input logic             ovf_flag,
  input logic             cmp_flag
);
  logic cnt_wr, flag_wr;
  assign cnt_wr  = wr_en && (wr_addr == 2'd1);
  assign flag_wr = wr_en && (wr_addr == 2'd3);

  a_r2_halt_when_off: assert property (@(posedge clk) disable iff (!rst_i)
    (csel == 3'd0 && !cnt_wr) |=> (cnt == $past(cnt)));

  a_r5_reload_after_match: assert property (@(posedge clk) disable iff (!rst_i)
    ((mode == 2'd2 || mode == 2'd3) && tick && !cnt_wr && cnt == cmp_act) |=> (cnt == '0));

  a_r7_pwm_single_step: assert property (@(posedge clk) disable iff (!rst_i)
    (mode == 2'd1 && !cnt_wr) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

  a_r6_wave_needs_tick: assert property (@(posedge clk) disable iff (!rst_i)
    !tick |=> $stable(wave_out));

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    (ovf_flag && !(flag_wr && wr_d0)) |=> ovf_flag);

  a_r11_cmp_set_on_tick: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(cmp_flag) |-> $past(tick));
endmodule

bind tc8_timer tc8_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_i    (rst_i),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_d0    (wr_data[0]),
  .csel     (csel_q),
  .mode     (mode_q),
  .tick     (tick),
  .cnt      (cnt),
  .cmp_act  (cmp_act),
  .wave_out (wave_out),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag)
);

// File: tb/tc8_timer_bench.sv
`timescale 1ns/1ps
module tc8_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ext_pin = 1'b0;
  logic [7:0] cnt;
  logic       wave_out, ovf_flag, cmp_flag, irq;

  always #2.5 clk = ~clk;

  tc8_timer u_tc8_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_pin(ext_pin), .cnt(cnt), .wave_out(wave_out), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .irq(irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int m_cnt, m_ocr, m_buf, m_psc, m_csel, m_mode;
  bit m_up, m_wave, m_blk, m_ovf, m_cmpf, m_mo, m_mc;
  bit m_h1, m_h2, m_h3, m_rs1, m_rs2;

  task automatic model_reset();
    m_cnt = 0; m_ocr = 0; m_buf = 0; m_psc = 0; m_csel = 0; m_mode = 0;
    m_up = 1; m_wave = 0; m_blk = 0; m_ovf = 0; m_cmpf = 0; m_mo = 0; m_mc = 0;
    m_h1 = 0; m_h2 = 0; m_h3 = 0;
  endtask

  task automatic model_step();
    bit t, cwr, owr, fwr, ctl, te, pwm, hit, match, oev;
    int n_cnt, n_ocr, n_buf;
    bit n_up, n_wave, n_blk, n_ovf, n_cmpf;
    case (m_csel)
      1: t = 1;
      2: t = (m_psc % 8) == 7;
      3: t = (m_psc % 64) == 63;
      4: t = (m_psc % 256) == 255;
      5: t = (m_psc % 1024) == 1023;
      6: t = !m_h2 && m_h3;
      7: t = m_h2 && !m_h3;
      default: t = 0;
    endcase
    ctl = wr_en && wr_addr == 2'd0;
    cwr = wr_en && wr_addr == 2'd1;
    owr = wr_en && wr_addr == 2'd2;
    fwr = wr_en && wr_addr == 2'd3;
    te  = t && !cwr;
    pwm = (m_mode == 1);
    hit = (m_cnt == m_ocr);
    match = te && !m_blk && hit;
    oev = te && (pwm ? (!m_up && m_cnt == 0) : (m_cnt == 255));
    n_cnt = m_cnt;
    if (cwr) n_cnt = int'(wr_data);
    else if (te) begin
      if (m_mode == 0)   n_cnt = (m_cnt + 1) % 256;
      else if (!pwm)     n_cnt = hit ? 0 : (m_cnt + 1) % 256;
      else if (m_up)     n_cnt = (m_cnt == 255) ? 254 : m_cnt + 1;
      else               n_cnt = (m_cnt == 0) ? 1 : m_cnt - 1;
    end
    n_up = !pwm ? 1'b1 : (te ? (m_up ? (m_cnt != 255) : (m_cnt == 0)) : m_up);
    n_wave = m_wave;
    if (match) begin
      if (pwm)              n_wave = !m_up;
      else if (m_mode == 3) n_wave = !m_wave;
    end
    n_buf = owr ? int'(wr_data) : m_buf;
    n_ocr = !pwm ? n_buf : ((te && m_up && m_cnt == 255) ? m_buf : m_ocr);
    n_blk = cwr ? 1'b1 : (te ? 1'b0 : m_blk);
    n_ovf  = oev   || (m_ovf  && !(fwr && wr_data[0]));
    n_cmpf = match || (m_cmpf && !(fwr && wr_data[1]));
    if (fwr) begin m_mo = wr_data[4]; m_mc = wr_data[5]; end
    m_psc = (ctl && wr_data[6]) ? 0 : (m_psc + 1) % 1024;
    if (ctl) begin m_csel = int'(wr_data[2:0]); m_mode = int'(wr_data[4:3]); end
    m_h3 = m_h2; m_h2 = m_h1; m_h1 = ext_pin;
    m_cnt = n_cnt; m_ocr = n_ocr; m_buf = n_buf; m_up = n_up; m_wave = n_wave;
    m_blk = n_blk; m_ovf = n_ovf; m_cmpf = n_cmpf;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; model_reset();
    end else begin
      if (!m_rs2) model_reset();
      else        model_step();
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("cnt", int'(cnt), m_cnt);
      check("wave_out", int'(wave_out), int'(m_wave));
      check("ovf_flag", int'(ovf_flag), int'(m_ovf));
      check("cmp_flag", int'(cmp_flag), int'(m_cmpf));
      check("irq", int'(irq), int'((m_ovf && m_mo) || (m_cmpf && m_mc)));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      idle(4);
      ext_pin = 1'b0;
      idle(3);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL %s watchdog act=running exp=finished", tag);
    finish_run();
  end

  initial begin
    tag = "R1";                  // reset state, including the two-clock release
    idle(3);
    rst_n = 1'b1;
    idle(4);
    tag = "R11"; wr(2'd3, 8'h30);          // both masks on
    tag = "R4";  wr(2'd0, 8'h01); idle(600);   // wrap-around, every clock
    tag = "R11"; wr(2'd3, 8'h31); idle(5);     // clear overflow only
    wr(2'd3, 8'h03); idle(20);                 // clear both, masks off
    tag = "R2";  wr(2'd0, 8'h02); idle(100);   // divide by 8
    tag = "R12"; wr(2'd0, 8'h42); idle(50);    // prescaler restart
    tag = "R2";  wr(2'd0, 8'h03); idle(300);
    wr(2'd0, 8'h04); idle(600);
    wr(2'd0, 8'h05); idle(2100);
    wr(2'd0, 8'h00); idle(50);                 // source off: hold
    tag = "R3";  wr(2'd0, 8'h07); pin_pulses(20);   // rising edges
    wr(2'd0, 8'h06); pin_pulses(20);                // falling edges
    tag = "R5";  wr(2'd2, 8'd10); wr(2'd1, 8'd0); wr(2'd0, 8'h11); idle(60);
    wr(2'd1, 8'd250); idle(40);                // above compare: passes 0xFF
    tag = "R6";  wr(2'd0, 8'h19); idle(60);
    tag = "R10"; wr(2'd3, 8'h33); wr(2'd1, 8'd10); idle(30);
    wr(2'd0, 8'h1A); wr(2'd1, 8'd10); idle(40);     // slow ticks, write lands on compare
    tag = "R7";  wr(2'd2, 8'h40); wr(2'd0, 8'h09); idle(1100);
    tag = "R8";  wr(2'd2, 8'hC0); idle(1100);
    tag = "R9";  wr(2'd2, 8'h00); idle(600);
    wr(2'd2, 8'hFF); idle(600);
    tag = "R10"; wr(2'd1, 8'h80); idle(600);
    finish_run();
  end
endmodule